// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

The block drives a set of independent pulse-width-modulated outputs. Each channel has a single 32-bit control word that software writes over a word-addressed register port. The word holds three fields: a run flag, an 8-bit on-count and a 13-bit clock divider.

A running channel slows the system clock by (divider + 1) to form ticks. It counts 256 ticks per frame. Its output is high during the first on-count ticks of every frame.

Software enables or disables a channel with read-modify-write, so readback returns the stored word exactly. Bits outside the three fields read as zero. Changing a running channel never cuts a frame short. The new on-count and divider are held aside and take effect at the next frame start.

Top module: `pwm_ctrl`

## Requirements
- R1: Control word layout: run flag at bit 31, on-count at bits 23:16, divider at bits 12:0. All other bits are dropped on write and read as zero.
- R2: Channel n is at byte offset 16*n, for n from 0 to NUM_CH-1. A write replaces the whole word. The combinational read returns the stored fields in the R1 layout.
- R3: An address that is not a multiple of 16, or whose index is NUM_CH or more, reads as zero. A write to such an address changes no channel and no output.
- R4: While running, each tick lasts (divider + 1) clock cycles and each frame lasts 256 ticks.
- R5: The output is high exactly while the tick number within the frame is less than the on-count. An on-count of 0 gives a constant low output.
- R6: After the run flag is cleared, the output stays low and the counters stay at zero. Writing 0 clears the whole configuration.
- R7: Suppose a write at clock edge k sets the run flag. The output is still low in the cycle after edge k. The first frame starts at tick 0 in the cycle after edge k+1, using the values from that write.
- R8: On-count and divider writes to a running channel take effect only at the next frame boundary. The frame in progress completes with the old values.
- R9: Channels run independently. Activity on one channel does not change another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational readback of the addressed word |
| pwm_o | output | NUM_CH | Modulated outputs, one per channel |

## Verification
The hardest case to reach is a reconfiguration that lands mid-frame. The test must show that the old on-count holds until tick 255 ends, and that the new divider stretches only the frames after it.

The bench starts a channel and counts cycles from the known start point given by R7. It issues the new write from inside its per-cycle checking loop, partway through the first frame. It then compares every cycle of two frames against a pattern computed from tick = floor(j/(divider+1)) mod 256.

A separate sweep covers every channel with several dividers and on-counts, including 0 and 255. During that sweep it checks that all idle channels stay low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int WORD_W    = 32;
  localparam int DUTY_W    = 8;
  localparam int SCALE_W   = 13;
  localparam int EN_BIT    = 31;
  localparam int DUTY_LSB  = 16;
  localparam int SCALE_LSB = 0;
  localparam int FRAME_LEN = 1 << DUTY_W;

  typedef struct packed {
    logic               en;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } ch_cfg_t;

  function automatic ch_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    ch_cfg_t c;
    c.en    = w[EN_BIT];
    c.duty  = w[DUTY_LSB +: DUTY_W];
    c.scale = w[SCALE_LSB +: SCALE_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(ch_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]                 = c.en;
    w[DUTY_LSB +: DUTY_W]     = c.duty;
    w[SCALE_LSB +: SCALE_W]   = c.scale;
    return w;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               step_o
);
  logic [SCALE_W-1:0] cnt_q;

  assign step_o = run_i && (cnt_q == scale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || step_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // divider count never passes the active divider value
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= scale_i);

  // stopped prescaler restarts from zero
  assert_cnt_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ch_cfg_t cfg_i,
  output logic    pwm_o
);
  logic               run_q;
  logic [DUTY_W-1:0]  tick_q;
  logic [DUTY_W-1:0]  act_duty_q;
  logic [SCALE_W-1:0] act_scale_q;
  logic               step;
  logic               frame_end;

  pwm_prescaler u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .scale_i (act_scale_q),
    .step_o  (step)
  );

  assign frame_end = step && (tick_q == {DUTY_W{1'b1}});

  // idle: shadow follows config so the first frame uses fresh values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      tick_q      <= '0;
      act_duty_q  <= '0;
      act_scale_q <= '0;
    end else begin
      run_q <= cfg_i.en;
      if (!run_q) begin
        tick_q      <= '0;
        act_duty_q  <= cfg_i.duty;
        act_scale_q <= cfg_i.scale;
      end else if (step) begin
        tick_q <= tick_q + 1'b1;
        if (frame_end) begin
          act_duty_q  <= cfg_i.duty;
          act_scale_q <= cfg_i.scale;
        end
      end
    end
  end

  assign pwm_o = run_q && (tick_q < act_duty_q);

  assert_shadow_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !frame_end |=> $stable(act_duty_q) && $stable(act_scale_q));

  assert_zero_duty_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o |-> act_duty_q != '0);

  assert_idle_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> tick_q == '0);

  assert_frame_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cfg_i.en && frame_end |=> tick_q == '0);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [NUM_CH-1:0]   pwm_o
);
  localparam int SLOT_LSB = 4;
  localparam int IDX_W    = ADDR_W - SLOT_LSB;

  logic [IDX_W-1:0] ch_idx;
  logic             hit;
  ch_cfg_t          cfg_q [NUM_CH];

  assign ch_idx = addr_i[ADDR_W-1:SLOT_LSB];
  assign hit    = (addr_i[SLOT_LSB-1:0] == '0) &&
                  ({1'b0, ch_idx} < (IDX_W+1)'(NUM_CH));

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (hit && ch_idx == IDX_W'(i)) rdata_o = cfg_to_word(cfg_q[i]);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && hit && (ch_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q[g] <= '0;
      else if (sel) cfg_q[g] <= word_to_cfg(wdata_i);
    end

    pwm_channel u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg_q[g]),
      .pwm_o  (pwm_o[g])
    );

    assert_wr_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == ADDR_W'(g << SLOT_LSB)
      |=> cfg_to_word(cfg_q[g]) ==
          ($past(wdata_i) & ((32'h1 << EN_BIT) | (32'hFF << DUTY_LSB) | 32'h1FFF)));

    assert_other_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i == ADDR_W'(g << SLOT_LSB)) |=> $stable(cfg_q[g]));
  end
endmodule

// File: tb/tb_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_ctrl;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int LIMIT  = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] pwm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata, exp, req);
  endtask

  function automatic logic exp_pwm(int j, int duty, int sc);
    return ((j / (sc + 1)) % 256) < duty;
  endfunction

  function automatic logic [31:0] mk(int en, int duty, int sc);
    return (32'(en) << 31) | (32'(duty) << 16) | 32'(sc);
  endfunction

  // write then land on the first sample of frame 0 (R7)
  task automatic start(input int ch, input logic [31:0] w);
    wr(ADDR_W'(ch << 4), w);
    chk({31'b0, pwm[ch]}, 32'd0, "R7 low before start");
    @(negedge clk);
  endtask

  initial begin
    int duties[5];
    int scales[3];
    duties = '{0, 1, 77, 128, 255};
    scales = '{0, 1, 3};
    repeat (3) @(negedge clk);
    // reset state
    chk({28'b0, pwm}, 32'd0, "R6 reset outputs");
    for (int c = 0; c < NUM_CH; c++) rd(ADDR_W'(c << 4), 32'd0, "R2 reset readback");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 field masking and placement
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h80FF_1FFF, "R1 masked readback");
    wr(8'h20, 32'h0012_0005);
    rd(8'h20, 32'h0012_0005, "R2 exact readback");
    rd(8'h10, 32'd0, "R2 neighbour untouched");
    wr(8'h20, 32'd0);
    rd(8'h20, 32'd0, "R6 zero write clears");

    // R3 unmapped addresses
    wr(8'h14, 32'h80FF_0000);
    wr(8'h40, 32'h80FF_0000);
    wr(8'hF0, 32'h80FF_0000);
    rd(8'h14, 32'd0, "R3 misaligned read");
    rd(8'h40, 32'd0, "R3 out of range read");
    for (int c = 0; c < NUM_CH; c++) rd(ADDR_W'(c << 4), 32'd0, "R3 no channel written");
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk({28'b0, pwm}, 32'd0, "R3 outputs stay low");
    end

    // sweep channels, dividers and on-counts (R4 R5 R7 R9)
    for (int c = 0; c < NUM_CH; c++)
      for (int s = 0; s < 3; s++)
        for (int d = 0; d < 5; d++) begin
          start(c, mk(1, duties[d], scales[s]));
          for (int j = 0; j < 256 * (scales[s] + 1); j++) begin
            chk({31'b0, pwm[c]}, {31'b0, exp_pwm(j, duties[d], scales[s])}, "R4 R5 frame");
            chk({28'b0, pwm & ~(4'b1 << c)}, 32'd0, "R9 idle channels low");
            @(negedge clk);
          end
          wr(ADDR_W'(c << 4), 32'd0);
          @(negedge clk);
        end

    // R6 clearing the run flag keeps fields and silences output
    start(0, mk(1, 255, 0));
    chk({31'b0, pwm[0]}, 32'd1, "R7 high at first tick");
    wr(8'h00, mk(0, 255, 0));
    @(negedge clk);
    for (int k = 0; k < 600; k++) begin
      chk({31'b0, pwm[0]}, 32'd0, "R6 disabled output low");
      @(negedge clk);
    end
    rd(8'h00, 32'h00FF_0000, "R6 fields kept");
    wr(8'h00, 32'd0);

    // R8 mid-frame reconfiguration, new divider and on-count
    start(1, mk(1, 64, 0));
    for (int j = 0; j < 768; j++) begin
      logic e;
      e = (j < 256) ? (j < 64) : (((j - 256) / 2) < 200);
      chk({31'b0, pwm[1]}, {31'b0, e}, "R8 boundary update");
      if (j == 100) begin wr_en = 1'b1; addr = 8'h10; wdata = mk(1, 200, 1); end
      if (j == 101) wr_en = 1'b0;
      @(negedge clk);
    end
    wr(8'h10, 32'd0);

    // R9 two channels together, channel 3 starts two cycles after channel 0
    start(0, mk(1, 10, 0));
    wr(8'h30, mk(1, 200, 1));
    @(negedge clk);
    for (int j = 0; j < 512; j++) begin
      chk({31'b0, pwm[3]}, {31'b0, exp_pwm(j, 200, 1)}, "R9 channel 3");
      chk({31'b0, pwm[0]}, {31'b0, exp_pwm(j + 2, 10, 0)}, "R9 channel 0");
      @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule